// File: doc/BRIEF.md
# Download packet parser with checksum check

This block sits behind the byte interface of a serial slave and turns the stream of bytes written by a host into command packets for an in-circuit code loader. It watches for a two-byte start marker, then reads a length byte and the number of body bytes that byte declares. The body holds a command byte, a 32-bit address sent most significant byte first, and an optional payload. A final checksum byte closes the packet.

Payload bytes are passed on as they arrive, each with a valid strobe and its own byte address. The first payload byte takes the packet address and each later one takes the next address. When the checksum byte arrives, a one-cycle done pulse reports the command and whether the packet was accepted. A response byte is also held for the host to fetch in a later read transaction: 0x06 means accepted and 0x07 means rejected. Acceptance means only that the framing, length, command code and checksum were correct. It says nothing about whether the command later succeeds. Running the commands and handling the bus bits are left to other blocks.

Top module: `dl_pkt_parser`

## Requirements
- R1: After reset, resp_o is 0x00 and both pay_valid_o and done_o are low.
- R2: A packet starts only after a 0x07 byte is followed directly by a 0x0E byte. Any other leading bytes are thrown away. A 0x07 that follows a 0x07 keeps the parser waiting for 0x0E, and any other byte sends it back to waiting for 0x07.
- R3: The byte after the marker is the length L. It counts the body bytes: one command byte, four address bytes and L-5 payload bytes. Each payload byte shows up on pay_data_o with pay_valid_o high for one cycle, in the cycle after the byte is accepted.
- R4: Body bytes 2 to 5 form the address, most significant byte first. The first payload byte has this address and each later one has the address before it plus 1, wrapping modulo 2^32.
- R5: A packet passes the checksum test when the 8-bit sum of L, all L body bytes and the checksum byte is 0x00. The marker bytes are not part of the sum.
- R6: The only valid command bytes are 0x45, 0x57, 0x56, 0x50 and 0x52. A packet with any other command byte still uses up L body bytes and the checksum byte, sends out no payload, and is rejected.
- R7: If L is below 5, the parser still takes exactly L body bytes and then the checksum byte, and the packet is rejected.
- R8: One cycle after the checksum byte is accepted, done_o is high for one cycle. It comes with done_cmd_o, which is the command byte (0x00 when L is 0), and done_ok_o, which is high only for a packet that passes R5, R6 and R7.
- R9: In the same cycle as done_o, resp_o becomes 0x06 if the packet was accepted and 0x07 if it was rejected. It keeps that value until the next done_o.
- R10: Cycles with rx_valid_i low do not change how a packet is parsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Strobe: a received byte is present on rx_data_i |
| rx_data_i | input | 8 | Received byte |
| pay_valid_o | output | 1 | Payload byte strobe |
| pay_data_o | output | 8 | Payload byte |
| pay_addr_o | output | 32 | Address of the payload byte |
| done_o | output | 1 | Pulse: the packet has ended |
| done_cmd_o | output | 8 | Command byte of the packet that ended |
| done_ok_o | output | 1 | The packet that ended was accepted |
| resp_o | output | 8 | Response byte the host reads back |

## Verification
The bench builds the block with its default parameters: a 32-bit address, an 8-bit length and a maximum length of 255. This makes the largest payload of 250 bytes and a payload address that wraps past 0xFFFFFFFF reachable. With these values, every length byte from 0 to 255 can occur. That lets the bench send packets that are too short, packets with no payload, and packets of full length. It mixes them with random garbage before the marker, gaps between bytes, wrong command codes and corrupted checksums.

// File: rtl/dl_pkg.sv
package dl_pkg;
  localparam logic [7:0] MARK0    = 8'h07;
  localparam logic [7:0] MARK1    = 8'h0E;
  localparam logic [7:0] RESP_ACK = 8'h06;
  localparam logic [7:0] RESP_NAK = 8'h07;

  localparam logic [7:0] CMD_ERASE   = 8'h45;
  localparam logic [7:0] CMD_WRITE   = 8'h57;
  localparam logic [7:0] CMD_VERIFY  = 8'h56;
  localparam logic [7:0] CMD_PROTECT = 8'h50;
  localparam logic [7:0] CMD_RUN     = 8'h52;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_MARK,
    ST_LEN,
    ST_BODY,
    ST_SUM
  } pst_e;
endpackage

// File: rtl/dl_cmd_check.sv
module dl_cmd_check
  import dl_pkg::*;
(
  input  logic [7:0] cmd_i,
  output logic       ok_o
);
  always_comb begin
    unique case (cmd_i)
      CMD_ERASE, CMD_WRITE, CMD_VERIFY, CMD_PROTECT, CMD_RUN: ok_o = 1'b1;
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dl_sum_acc.sv
module dl_sum_acc #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         add_i,
  input  logic [W-1:0] byte_i,
  output logic         zero_o
);
  logic [W-1:0] sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sum_q <= '0;
    else if (load_i)  sum_q <= byte_i;
    else if (add_i)   sum_q <= sum_q + byte_i;
  end

  // sum including the byte on the input now (used on the checksum byte)
  logic [W-1:0] sum_next;
  assign sum_next = sum_q + byte_i;
  assign zero_o   = (sum_next == '0);
endmodule

// File: rtl/dl_addr_gen.sv
module dl_addr_gen #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              inc_i,
  input  logic [7:0]        byte_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q <= '0;
    else if (shift_i)  addr_q <= {addr_q[ADDR_W-9:0], byte_i};
    else if (inc_i)    addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/dl_pkt_parser.sv
module dl_pkt_parser
  import dl_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 8,
  parameter int MAX_LEN = 255
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              pay_valid_o,
  output logic [7:0]        pay_data_o,
  output logic [ADDR_W-1:0] pay_addr_o,
  output logic              done_o,
  output logic [7:0]        done_cmd_o,
  output logic              done_ok_o,
  output logic [7:0]        resp_o
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int MIN_LEN    = 1 + ADDR_BYTES;

  pst_e             st_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] idx_q;
  logic [7:0]       cmd_q;

  logic in_body, in_sum, last_body, len_ok, cmd_ok, addr_byte, pay_byte, sum_zero;
  logic [ADDR_W-1:0] addr_cur;

  assign in_body   = rx_valid_i && (st_q == ST_BODY);
  assign in_sum    = rx_valid_i && (st_q == ST_SUM);
  assign last_body = ({1'b0, idx_q} + 1'b1) == {1'b0, len_q};
  assign len_ok    = (int'(len_q) >= MIN_LEN) && (int'(len_q) <= MAX_LEN);
  assign addr_byte = in_body && (idx_q != '0) && (int'(idx_q) <= ADDR_BYTES);
  assign pay_byte  = in_body && (int'(idx_q) >= MIN_LEN) && cmd_ok && len_ok;

  dl_cmd_check u_cmd (
    .cmd_i (cmd_q),
    .ok_o  (cmd_ok)
  );

  dl_sum_acc #(.W(8)) u_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (rx_valid_i && (st_q == ST_LEN)),
    .add_i  (in_body),
    .byte_i (rx_data_i),
    .zero_o (sum_zero)
  );

  dl_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (addr_byte),
    .inc_i   (pay_byte),
    .byte_i  (rx_data_i),
    .addr_o  (addr_cur)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_HUNT;
      len_q <= '0;
      idx_q <= '0;
      cmd_q <= '0;
    end else if (rx_valid_i) begin
      unique case (st_q)
        ST_HUNT: if (rx_data_i == MARK0) st_q <= ST_MARK;
        ST_MARK: begin
          if (rx_data_i == MARK1)      st_q <= ST_LEN;
          else if (rx_data_i != MARK0) st_q <= ST_HUNT;
        end
        ST_LEN: begin
          len_q <= rx_data_i[LEN_W-1:0];
          idx_q <= '0;
          cmd_q <= '0;
          st_q  <= (rx_data_i == 8'h00) ? ST_SUM : ST_BODY;
        end
        ST_BODY: begin
          if (idx_q == '0) cmd_q <= rx_data_i;
          idx_q <= idx_q + 1'b1;
          if (last_body) st_q <= ST_SUM;
        end
        ST_SUM:  st_q <= ST_HUNT;
        default: st_q <= ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pay_valid_o <= 1'b0;
      pay_data_o  <= '0;
      pay_addr_o  <= '0;
      done_o      <= 1'b0;
      done_cmd_o  <= '0;
      done_ok_o   <= 1'b0;
      resp_o      <= '0;
    end else begin
      pay_valid_o <= pay_byte;
      done_o      <= in_sum;
      if (pay_byte) begin
        pay_data_o <= rx_data_i;
        pay_addr_o <= addr_cur;
      end
      if (in_sum) begin
        done_cmd_o <= cmd_q;
        done_ok_o  <= sum_zero && len_ok && cmd_ok;
        resp_o     <= (sum_zero && len_ok && cmd_ok) ? RESP_ACK : RESP_NAK;
      end
    end
  end
endmodule

// File: rtl/dl_pkt_parser_chk.sv
module dl_pkt_parser_chk
  import dl_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pay_valid_o,
  input logic [ADDR_W-1:0] pay_addr_o,
  input logic              done_o,
  input logic [7:0]        done_cmd_o,
  input logic              done_ok_o,
  input logic [7:0]        resp_o
);
  p_resp_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> resp_o == (done_ok_o ? RESP_ACK : RESP_NAK));

  p_resp_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(resp_o) || done_o);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_no_overlap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && pay_valid_o));

  p_addr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_valid_o |=> !pay_valid_o || (pay_addr_o == $past(pay_addr_o) + 1'b1));

  p_ok_cmd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && done_ok_o) |-> (done_cmd_o == CMD_ERASE || done_cmd_o == CMD_WRITE ||
      done_cmd_o == CMD_VERIFY || done_cmd_o == CMD_PROTECT || done_cmd_o == CMD_RUN));
endmodule

bind dl_pkt_parser dl_pkt_parser_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pay_valid_o (pay_valid_o),
  .pay_addr_o  (pay_addr_o),
  .done_o      (done_o),
  .done_cmd_o  (done_cmd_o),
  .done_ok_o   (done_ok_o),
  .resp_o      (resp_o)
);

// File: tb/dl_pkt_parser_tb.sv
module dl_pkt_parser_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        pay_valid, done, done_ok;
  logic [7:0]  pay_data, done_cmd, resp;
  logic [31:0] pay_addr;

  always #4 clk = ~clk;

  dl_pkt_parser u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .pay_valid_o(pay_valid), .pay_data_o(pay_data), .pay_addr_o(pay_addr),
    .done_o(done), .done_cmd_o(done_cmd), .done_ok_o(done_ok), .resp_o(resp)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // monitor
  logic [7:0]  got_d [256];
  logic [31:0] got_a [256];
  int          n_pay = 0, n_done = 0;
  logic [7:0]  last_cmd;
  logic        last_ok;

  always @(negedge clk) begin
    if (pay_valid && n_pay < 256) begin
      got_d[n_pay] = pay_data;
      got_a[n_pay] = pay_addr;
      n_pay++;
    end
    if (done) begin
      n_done++;
      last_cmd = done_cmd;
      last_ok  = done_ok;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input bit gaps);
    int g;
    g = gaps ? int'($urandom_range(0, 2)) : 0;
    repeat (g) @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  function automatic bit cmd_valid(input logic [7:0] c);
    return c == 8'h45 || c == 8'h57 || c == 8'h56 || c == 8'h50 || c == 8'h52;
  endfunction

  logic [7:0] body [256];

  // Sends marker, length, body[0..len-1], checksum; then checks the outcome.
  task automatic run_pkt(input int len, input bit bad_cs, input bit gaps, input string tag);
    logic [7:0]  sum, cs;
    logic [31:0] base;
    bit          exp_ok, exp_pay;
    int          np;
    n_pay = 0;
    n_done = 0;
    sum = 8'(len);
    for (int i = 0; i < len; i++) sum += body[i];
    cs = 8'h00 - sum;
    if (bad_cs) cs = cs + 8'(1 + $urandom_range(0, 254));
    put(8'h07, gaps);
    put(8'h0E, gaps);
    put(8'(len), gaps);
    for (int i = 0; i < len; i++) put(body[i], gaps);
    put(cs, gaps);
    repeat (2) @(negedge clk);
    exp_pay = (len >= 5) && cmd_valid(body[0]);
    exp_ok  = exp_pay && !bad_cs;
    np      = exp_pay ? len - 5 : 0;
    base    = {body[1], body[2], body[3], body[4]};
    chk(n_done == 1, {tag, " R8 done count"}, n_done, 1);
    chk(last_ok == exp_ok, {tag, " R5 R6 R7 done_ok"}, last_ok, exp_ok);
    chk(last_cmd == (len == 0 ? 8'h00 : body[0]), {tag, " R8 done_cmd"}, last_cmd, body[0]);
    chk(resp == (exp_ok ? 8'h06 : 8'h07), {tag, " R9 resp"}, resp, exp_ok ? 8'h06 : 8'h07);
    chk(n_pay == np, {tag, " R3 payload count"}, n_pay, np);
    for (int i = 0; i < np && i < n_pay; i++) begin
      if (got_d[i] !== body[5+i] || got_a[i] !== base + 32'(i)) begin
        chk(0, {tag, " R3 R4 payload byte/addr"}, {got_a[i], 24'h0, got_d[i]},
            {base + 32'(i), 24'h0, body[5+i]});
        break;
      end
    end
    if (np > 0) chk(got_a[0] == base, {tag, " R4 first addr"}, got_a[0], base);
  endtask

  task automatic fill(input logic [7:0] c, input logic [31:0] a, input int len);
    body[0] = c;
    body[1] = a[31:24]; body[2] = a[23:16]; body[3] = a[15:8]; body[4] = a[7:0];
    for (int i = 5; i < 256; i++) body[i] = 8'($urandom);
    if (len < 0) body[0] = c;
  endtask

  function automatic logic [7:0] rnd_cmd();
    case ($urandom_range(0, 4))
      0: return 8'h45;
      1: return 8'h57;
      2: return 8'h56;
      3: return 8'h50;
      default: return 8'h52;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] g;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    chk(resp == 8'h00 && !pay_valid && !done, "R1 reset state", {resp, pay_valid, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(resp == 8'h00 && !pay_valid && !done, "R1 after reset release", {resp, pay_valid, done}, 0);

    // directed: write with zero payload
    fill(8'h57, 32'h0000_1000, 5);
    run_pkt(5, 0, 0, "d_len5");
    // directed: run command
    fill(8'h52, 32'h0000_0001, 5);
    run_pkt(5, 0, 0, "d_run");
    // R9 hold: garbage without a packet leaves resp
    n_done = 0;
    for (int i = 0; i < 10; i++) put(8'h55 + 8'(i), 1);
    put(8'h07, 0); put(8'h41, 0); put(8'h0E, 0);
    repeat (2) @(negedge clk);
    chk(n_done == 0 && resp == 8'h06, "R2 R9 garbage ignored, resp held", {n_done, resp}, 8'h06);
    // R2: repeated 0x07 before 0x0E
    put(8'h07, 0);
    fill(8'h57, 32'h2000_0000, 9);
    run_pkt(9, 0, 1, "d_r2_double07");
    // R2: 0x07 then junk aborts, then real packet
    put(8'h07, 0); put(8'h33, 0); put(8'h0E, 0); put(8'h06, 0);
    fill(8'h56, 32'h0000_0040, 12);
    run_pkt(12, 0, 0, "d_r2_abort");
    // R7: short lengths
    fill(8'h57, 32'h1234_5678, 0);
    run_pkt(0, 0, 0, "d_r7_len0");
    fill(8'h57, 32'h1234_5678, 3);
    run_pkt(3, 0, 1, "d_r7_len3");
    fill(8'h45, 32'h1234_5678, 4);
    run_pkt(4, 0, 0, "d_r7_len4");
    // R6: unknown command
    fill(8'h41, 32'h0000_0100, 10);
    run_pkt(10, 0, 0, "d_r6_badcmd");
    // R5: bad checksum still streams payload
    fill(8'h57, 32'h0000_0200, 8);
    run_pkt(8, 1, 0, "d_r5_badcs");
    // R4: address wrap
    fill(8'h57, 32'hFFFF_FFFE, 9);
    run_pkt(9, 0, 0, "d_r4_wrap");
    // R3: longest packet
    fill(8'h57, 32'h0001_0000, 255);
    run_pkt(255, 0, 0, "d_r3_len255");
    // R10: gaps on every byte
    fill(8'h50, 32'hFFFF_FFFF, 6);
    run_pkt(6, 0, 1, "d_r10_gaps");

    // random
    for (int k = 0; k < 60; k++) begin
      int len, ng;
      ng = $urandom_range(0, 4);
      for (int i = 0; i < ng; i++) begin
        g = 8'($urandom);
        if (g == 8'h07) g = 8'h08;
        put(g, 1);
      end
      len = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 4)) : int'($urandom_range(5, 40));
      fill(($urandom_range(0, 7) == 0) ? 8'($urandom) : rnd_cmd(), $urandom, len);
      run_pkt(len, $urandom_range(0, 4) == 0, $urandom_range(0, 1) == 1, "rnd R10");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule